// File: doc/BRIEF.md
# Serial Flash Sector Lock Controller

This block holds the volatile per-sector write protection of a serial NOR flash slave. It watches the serial clock, chip select and single data line of the host bus and recognises two commands: a write-enable command that arms a write-enable latch, and a lock-write command that loads a two-bit lock register for one sector. Each sector's write-lock bit is driven straight out as a "protected" flag, which the program/erase engine consults before it touches that sector. The engine reports back through a busy input, and lock writes are refused while it is busy.

Each lock register holds a write-lock bit and a lock-down bit. Once a sector's lock-down bit is set, its register is frozen until reset, which stands for power-up here. The serial inputs are oversampled by the system clock, so the bus clock must run well below it. All decisions are made when chip select rises. A frame counts only if chip select rises on the exact bit count of its command.

Top module: `spi_lock_ctrl`

## Requirements
- R1: After reset, every bit of `prot_o` is 0 and `wel_o` is 0.
- R2: A frame of exactly 8 bits carrying opcode 06h (bits sent MSB first, chip select rising after the 8th bit) sets `wel_o` to 1.
- R3: A 40-bit frame made of opcode E5h, a 24-bit address and a data byte, sent MSB first while `wel_o` is 1, `busy_i` is 0 and the sector's lock-down bit is 0, loads data bit 0 as that sector's write lock (seen on `prot_o`) and data bit 1 as its lock-down bit. Data bits 7 to 2 are ignored. `wel_o` then returns to 0.
- R4: A lock-write frame sent while `wel_o` is 0 changes no lock bit and leaves `wel_o` at 0.
- R5: If chip select rises after any bit count other than 8 for the write-enable opcode, or other than 40 for the lock-write opcode, the frame has no effect, and `wel_o` keeps its value.
- R6: A frame whose first byte is neither 06h nor E5h has no effect on `prot_o` or `wel_o`, whatever its length.
- R7: The target sector is given only by the top log2(NSECT) address bits, which are address bits 23 to 16 by default. The lower address bits do not matter.
- R8: While a sector's lock-down bit is 1, a valid lock-write frame to that sector changes neither of its lock bits, but it still clears `wel_o`.
- R9: A lock-write frame that ends while `busy_i` is 1 is rejected. `prot_o` stays unchanged and `wel_o` stays 1.
- R10: Reset clears lock-down bits, so a sector frozen before reset can be written again after reset.
- R11: A lock-write frame never changes the lock bits of any sector other than the one it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| sck | input | 1 | Serial bus clock, idle low, data taken on its rising edge |
| cs_n | input | 1 | Active-low chip select, frames a command |
| sdi | input | 1 | Serial data input, MSB first |
| busy_i | input | 1 | High while a program, erase or write cycle is running |
| wel_o | output | 1 | Write-enable latch |
| prot_o | output | NSECT | Per-sector protected flag (write-lock bit) |

## Verification
The hardest state to reach is a sector whose lock-down bit is set and which then receives a fully valid lock-write frame. Getting there takes a write-enable frame, an exact 40-bit frame with data bit 1 set, then a second write-enable and a second frame aimed at the same sector, with busy low at both frame ends. The random stimulus reaches it by placing a write-enable frame before most lock writes, by drawing target sectors from a small pool so that sectors are hit repeatedly, and by keeping lock-down rare so that most sectors stay writable. Directed frames add a freeze, a reset and a rewrite of the same sector, as well as frames one bit short and one bit long.

// File: rtl/spi_lock_pkg.sv
package spi_lock_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRLOCK = 8'hE5;
  localparam int CMD_BITS  = 8;
  localparam int DATA_BITS = 8;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_WREN,
    CMD_WRLOCK
  } cmd_e;
endpackage

// File: rtl/spi_lock_frontend.sv
module spi_lock_frontend #(
  parameter int FRAME_W = 40,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               sdi,
  output logic               frame_end,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic [FRAME_W-1:0] shreg
);
  // count saturates one past a full frame so overlong frames never match
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic sck_q, sck_d, cs_q, cs_d, sdi_q;
  logic sck_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      cs_q  <= 1'b1;
      cs_d  <= 1'b1;
      sdi_q <= 1'b0;
    end else begin
      sck_q <= sck;
      sck_d <= sck_q;
      cs_q  <= cs_n;
      cs_d  <= cs_q;
      sdi_q <= sdi;
    end
  end

  assign sck_rise  = sck_q & ~sck_d & ~cs_q;
  assign frame_end = cs_q & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst || cs_q) begin
      bit_cnt <= '0;
    end else if (sck_rise && bit_cnt != CNT_SAT) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_q};
    end
  end
endmodule

// File: rtl/spi_lock_decode.sv
module spi_lock_decode
  import spi_lock_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SIDX_W  = 8,
  parameter int FRAME_W = 40,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_end,
  input  logic [CNT_W-1:0]   bit_cnt,
  input  logic [FRAME_W-1:0] shreg,
  input  logic               busy_i,
  output logic               wel_o,
  output logic               wr_en,
  output logic [SIDX_W-1:0]  wr_sect,
  output logic               wr_wl,
  output logic               wr_ld
);
  // frame layout, oldest bit at the top: opcode | address | data
  localparam int ADDR_MSB = FRAME_W - CMD_BITS - 1;

  cmd_e cmd;
  logic wel_q;
  logic accept;
  logic unused_bits;

  always_comb begin
    cmd = CMD_NONE;
    if (frame_end) begin
      if (bit_cnt == CNT_W'(CMD_BITS) && shreg[CMD_BITS-1:0] == OP_WREN) begin
        cmd = CMD_WREN;
      end else if (bit_cnt == CNT_W'(FRAME_W) &&
                   shreg[FRAME_W-1 -: CMD_BITS] == OP_WRLOCK) begin
        cmd = CMD_WRLOCK;
      end
    end
  end

  assign accept  = (cmd == CMD_WRLOCK) && wel_q && !busy_i;
  assign wr_en   = accept;
  assign wr_sect = shreg[ADDR_MSB -: SIDX_W];
  assign wr_wl   = shreg[0];
  assign wr_ld   = shreg[1];
  assign wel_o   = wel_q;

  assign unused_bits = ^{shreg[ADDR_MSB-SIDX_W:2], ADDR_W[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q <= 1'b0;
    end else if (cmd == CMD_WREN) begin
      wel_q <= 1'b1;
    end else if (accept) begin
      wel_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_lock_bank.sv
module spi_lock_bank #(
  parameter int NSECT  = 256,
  parameter int SIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SIDX_W-1:0] wr_sect,
  input  logic              wr_wl,
  input  logic              wr_ld,
  output logic [NSECT-1:0]  wl_q,
  output logic [NSECT-1:0]  ld_q
);
  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    always_ff @(posedge clk) begin
      if (rst) begin
        wl_q[i] <= 1'b0;
        ld_q[i] <= 1'b0;
      end else if (wr_en && wr_sect == SIDX_W'(i) && !ld_q[i]) begin
        wl_q[i] <= wr_wl;
        ld_q[i] <= wr_ld;
      end
    end
  end
endmodule

// File: rtl/spi_lock_ctrl.sv
module spi_lock_ctrl
  import spi_lock_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NSECT  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             busy_i,
  output logic             wel_o,
  output logic [NSECT-1:0] prot_o
);
  localparam int SIDX_W  = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int FRAME_W = CMD_BITS + ADDR_W + DATA_BITS;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic               frame_end;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               wr_en, wr_wl, wr_ld;
  logic [SIDX_W-1:0]  wr_sect;
  logic [NSECT-1:0]   ld_q;

  spi_lock_frontend #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_fe (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .frame_end(frame_end), .bit_cnt(bit_cnt), .shreg(shreg)
  );

  spi_lock_decode #(.ADDR_W(ADDR_W), .SIDX_W(SIDX_W), .FRAME_W(FRAME_W),
                    .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .frame_end(frame_end), .bit_cnt(bit_cnt),
    .shreg(shreg), .busy_i(busy_i), .wel_o(wel_o), .wr_en(wr_en),
    .wr_sect(wr_sect), .wr_wl(wr_wl), .wr_ld(wr_ld)
  );

  spi_lock_bank #(.NSECT(NSECT), .SIDX_W(SIDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sect(wr_sect),
    .wr_wl(wr_wl), .wr_ld(wr_ld), .wl_q(prot_o), .ld_q(ld_q)
  );
endmodule

// File: rtl/spi_lock_chk.sv
module spi_lock_chk #(
  parameter int NSECT = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             busy_i,
  input logic             wel_o,
  input logic [NSECT-1:0] prot_o,
  input logic [NSECT-1:0] ld_q
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!wel_o && prot_o == '0));

  a_r4_lock_needs_wel: assert property (@(posedge clk) disable iff (rst)
    (prot_o != $past(prot_o)) |-> $past(wel_o));

  a_r8_lockdown_sticky: assert property (@(posedge clk) disable iff (rst)
    ((ld_q & $past(ld_q)) == $past(ld_q)));

  a_r8_frozen_wl: assert property (@(posedge clk) disable iff (rst)
    (((prot_o ^ $past(prot_o)) & $past(ld_q)) == '0));

  a_r9_busy_reject: assert property (@(posedge clk) disable iff (rst)
    $past(busy_i) |-> $stable(prot_o));

  a_r2_wel_set_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(wel_o) |-> $past(cs_n, 2));

  a_r3_wel_clr_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(wel_o) |-> $past(cs_n, 2));
endmodule

bind spi_lock_ctrl spi_lock_chk #(.NSECT(NSECT)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .busy_i(busy_i),
  .wel_o(wel_o), .prot_o(prot_o), .ld_q(ld_q)
);

// File: tb/sim_spi_lock_ctrl.sv
module sim_spi_lock_ctrl;
  localparam int NSECT = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic busy_i = 1'b0;
  logic wel_o;
  logic [NSECT-1:0] prot_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [NSECT-1:0] m_prot = '0;
  logic [NSECT-1:0] m_ld = '0;
  logic m_wel = 1'b0;

  always #2.5 clk = ~clk;

  spi_lock_ctrl #(.ADDR_W(24), .NSECT(NSECT)) u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .busy_i(busy_i), .wel_o(wel_o), .prot_o(prot_o)
  );

  task automatic check(input string tag);
    n_chk++;
    if (wel_o !== m_wel) begin
      n_bad++;
      $display("FAIL %s wel_o actual=%0b expected=%0b", tag, wel_o, m_wel);
    end
    n_chk++;
    if (prot_o !== m_prot) begin
      n_bad++;
      $display("FAIL %s prot_o actual=%h expected=%h", tag, prot_o, m_prot);
    end
  endtask

  // reference behaviour taken from the requirements
  task automatic model(input logic [47:0] v, input int nb, input logic bsy);
    if (nb == 8 && v[7:0] == 8'h06) begin
      m_wel = 1'b1;
    end else if (nb == 40 && v[39:32] == 8'hE5 && m_wel && !bsy) begin
      if (!m_ld[v[31:24]]) begin
        m_prot[v[31:24]] = v[0];
        m_ld[v[31:24]]   = v[1];
      end
      m_wel = 1'b0;
    end
  endtask

  task automatic send(input logic [47:0] v, input int nb, input logic bsy);
    @(negedge clk);
    busy_i = bsy;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = v[i];
      sck = 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    sck = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    busy_i = 1'b0;
    model(v, nb, bsy);
  endtask

  function automatic logic [47:0] lockf(input logic [7:0] s, input logic [15:0] lo,
                                        input logic [7:0] d, input logic [7:0] op);
    return {8'h00, op, s, lo, d};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_prot = '0;
    m_ld = '0;
    m_wel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset");

    send(lockf(8'd5, 16'h0000, 8'h01, 8'hE5), 40, 1'b0);
    check("R4 lock write without wel");

    send(48'h06, 8, 1'b0);
    check("R2 write enable");

    send(lockf(8'd5, 16'hABCD, 8'hFD, 8'hE5), 40, 1'b0);
    check("R3 R7 lock sector 5, reserved bits set, low address bits random");

    send(48'h06, 8, 1'b0);
    send(lockf(8'd7, 16'h0000, 8'h01, 8'h05), 40, 1'b0);
    check("R6 unknown opcode");

    send(lockf(8'd7, 16'h0000, 8'h01, 8'hE5) >> 1, 39, 1'b0);
    check("R5 frame one bit short");
    send({lockf(8'd7, 16'h0000, 8'h01, 8'hE5), 1'b1}, 41, 1'b0);
    check("R5 frame one bit long");
    send(48'h0C, 9, 1'b0);
    check("R5 write enable one bit long");

    send(lockf(8'd5, 16'h1234, 8'h00, 8'hE5), 40, 1'b1);
    check("R9 busy rejects");

    send(lockf(8'd9, 16'hFFFF, 8'h03, 8'hE5), 40, 1'b0);
    check("R3 R11 lock and freeze sector 9");

    send(48'h06, 8, 1'b0);
    send(lockf(8'd9, 16'h0001, 8'h00, 8'hE5), 40, 1'b0);
    check("R8 frozen sector keeps lock, wel cleared");

    do_reset();
    check("R10 R1 reset after freeze");
    send(48'h06, 8, 1'b0);
    send(lockf(8'd9, 16'h0000, 8'h00, 8'hE5), 40, 1'b0);
    send(48'h06, 8, 1'b0);
    send(lockf(8'd9, 16'h0000, 8'h01, 8'hE5), 40, 1'b0);
    check("R10 sector 9 writable after reset");

    for (int k = 0; k < 160; k++) begin
      int kind;
      int nb;
      logic [7:0] s;
      logic [7:0] d;
      logic bsy;
      string tag;
      kind = int'($urandom % 10);
      case ($urandom % 5)
        0: s = 8'd0;
        1: s = 8'd1;
        2: s = 8'd255;
        3: s = 8'd9;
        default: s = 8'($urandom);
      endcase
      d = 8'($urandom);
      d[1] = (($urandom % 8) == 0);
      bsy = (($urandom % 5) == 0);
      if (kind < 5) begin
        send(48'h06, 8, 1'b0);
        send(lockf(s, 16'($urandom), d, 8'hE5), 40, bsy);
        tag = bsy ? "R9 random busy" : "R3 R8 R11 random lock write";
      end else if (kind < 7) begin
        send(lockf(s, 16'($urandom), d, 8'hE5), 40, bsy);
        tag = "R4 R3 random write without fresh enable";
      end else if (kind < 9) begin
        send(48'h06, 8, 1'b0);
        nb = 1 + int'($urandom % 45);
        send(lockf(s, 16'($urandom), d, 8'hE5), nb, 1'b0);
        tag = "R5 random chip select point";
      end else begin
        send(lockf(s, 16'($urandom), d, 8'($urandom | 32'h10)), 40, 1'b0);
        tag = "R6 random opcode";
      end
      check(tag);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule